// File: doc/BRIEF.md
# Four-Player Tap Host Reader

This block is the host end of a single joystick port to which a four-player tap may be attached. It drives three output lines: a parallel-load strobe, a shift clock and a sense drive line that is held low while a transaction runs. It watches five input lines: one serial data line for each of the four tap sockets, and a sense line on which an attached tap returns the shift clock inverted.

A start pulse begins a transaction. The block first checks that a tap is present by testing whether the sense line follows the shift clock with the opposite level. If a tap is found, the block either reads one button byte from each socket or reads the tap's 4-bit identity. In both cases the four sockets shift out together on the same clock, and the four serial streams are separated into per-socket results. Every output level is held for a dwell time in system clocks. The dwell is chosen at start and is never shorter than the input synchronizer delay plus one. All results change together on a one-cycle done pulse.

Top module: `mtap_host`

## Requirements
- R1: After reset, and whenever no transaction is running, `load_o`, `sclk_o` and `sense_drv_o` are high and `busy_o` is low. Reset clears `pads_o`, `id_o` and `present_o` and sets `players_o` to 1.
- R2: The first probe phase drives all three lines low. If the synchronized sense line then reads low, the transaction ends at once with the tap reported absent.
- R3: The second probe phase raises `sclk_o` only. The tap counts as present only if sense now reads low. A sense line stuck high is therefore reported absent.
- R4: On every done pulse, `players_o` is 4 when `present_o` is 1 and 1 otherwise.
- R5: A read begins with `sclk_o` high and `load_o` low. `load_o` is then pulsed high and back low while `sclk_o` stays high.
- R6: Each bit takes one `sclk_o`-high phase followed by one `sclk_o`-low phase, and the data lines are sampled at the end of the low phase. A button read takes eight bits, and the first bit sampled ends up in bit 7 of the byte.
- R7: `data_i[k]` feeds socket k, whose byte sits at `pads_o[8k+7:8k]`.
- R8: In identity mode (`id_mode_i`=1 at start) nine bits are clocked, and `id_o[k]` takes `data_i[k]` from the ninth sample. `pads_o` is unchanged.
- R9: `done_o` is a one-cycle pulse, raised in the same cycle that the lines return high and `busy_o` falls. When the tap is absent, a button read clears `pads_o` and an identity read clears `id_o`.
- R10: Each line level is held exactly max(`dwell_i`, 3) system clocks. `dwell_i` is captured at start, and the sense and data inputs pass through a two-stage synchronizer.
- R11: A start pulse while `busy_o` is high is ignored and has no effect on the running transaction or on its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, accepted when idle |
| id_mode_i | input | 1 | 1 = read identity, 0 = read buttons (captured at start) |
| dwell_i | input | 8 | Hold time per line level, in clocks (minimum 3) |
| data_i | input | 4 | Serial data from the four tap sockets |
| sense_i | input | 1 | Presence sense line from the tap |
| load_o | output | 1 | Parallel load strobe to the tap |
| sclk_o | output | 1 | Shift clock to the tap |
| sense_drv_o | output | 1 | Sense drive line, low during a transaction |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| present_o | output | 1 | Tap detected in the last transaction |
| players_o | output | 3 | Player count: 4 or 1 |
| pads_o | output | 32 | Four button bytes, socket k at bits 8k+7:8k |
| id_o | output | 4 | Tap identity, bit k from socket k |

## Verification
Button reads use different bytes on each socket, including asymmetric values such as A5/3C/F0/01 and 00/FF/81/7E. A swapped line or a reversed bit order therefore shows up in a specific socket and bit. Presence is tried three ways: with no tap, where sense reads low in the first probe; with sense stuck high, which fails only in the second probe; and with a real tap. Identity reads use serial-in levels that differ from the loaded buttons, so sampling the eighth bit instead of the ninth gives the wrong value. Dwell values of 0, 3, 5 and 10 show both the clamp and the exact hold length, and a start pulse in the middle of a transaction shows whether a second start is ignored.

// File: rtl/mtap_pkg.sv
// Shared types for the four-player tap host reader.
// Assumes: nothing beyond the definitions here.
package mtap_pkg;

    // Sequencer phases; each non-idle phase lasts one dwell period.
    typedef enum logic [2:0] {
        PH_IDLE     = 3'd0,
        PH_PROBE_LO = 3'd1,
        PH_PROBE_HI = 3'd2,
        PH_LOAD_HI  = 3'd3,
        PH_LOAD_LO  = 3'd4,
        PH_BIT_HI   = 3'd5,
        PH_BIT_LO   = 3'd6
    } phase_t;

    // Levels of the three host-driven port lines.
    typedef struct packed {
        logic load;
        logic sclk;
        logic drv;
    } lines_t;

endpackage

// File: rtl/mtap_sync.sv
// Multi-stage synchronizer for the asynchronous tap inputs.
// Assumes: each bit is independent; a skew of one cycle between bits
// is harmless because sampling happens well after every line has settled.
module mtap_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [STAGES-1:0][W-1:0] chain_q;

    // Shift the raw inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/mtap_dwell.sv
// Phase timer: each restart begins a period of the captured dwell length.
// Assumes: latch_i and restart_i are asserted together on a start, so the
// first period uses the freshly clamped value.
module mtap_dwell #(
    parameter int DW  = 8,
    parameter int MIN = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          latch_i,
    input  logic [DW-1:0] dwell_i,
    input  logic          restart_i,
    output logic          expire_o
);

    localparam logic [DW-1:0] MIN_V = DW'(MIN);

    logic [DW-1:0] eff_q;
    logic [DW-1:0] cnt_q;
    logic [DW-1:0] clamp_v;
    logic [DW-1:0] load_v;

    // Raise a too-short request to the minimum safe hold.
    assign clamp_v = (dwell_i < MIN_V) ? MIN_V : dwell_i;
    assign load_v  = latch_i ? clamp_v : eff_q;

    // Keep the dwell chosen at start for the whole transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eff_q <= MIN_V;
        end else if (latch_i) begin
            eff_q <= clamp_v;
        end
    end

    // Count down the current phase; zero marks its last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart_i) begin
            cnt_q <= load_v - 1'b1;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire_o = (cnt_q == '0);

endmodule

// File: rtl/mtap_seq.sv
// Transaction sequencer: presence probe, load pulse and bit clocking.
// Assumes: sense_s_i is already synchronized and expire_i marks the last
// cycle of each phase. Starts are taken only in the idle phase.
module mtap_seq #(
    parameter int BITS = 8,
    localparam int CW  = $clog2(BITS + 2)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            id_mode_i,
    input  logic            sense_s_i,
    input  logic            expire_i,
    output logic            latch_o,
    output logic            restart_o,
    output logic            sample_o,
    output logic            hit_o,
    output logic            miss_o,
    output logic            mode_o,
    output logic            busy_o,
    output logic            done_o,
    output mtap_pkg::lines_t lines_o
);
    import mtap_pkg::*;

    localparam logic [CW-1:0] LAST_BTN = CW'(BITS - 1);
    localparam logic [CW-1:0] LAST_ID  = CW'(BITS);

    phase_t      st_q, st_d;
    logic [CW-1:0] bit_q;
    logic        mode_q;
    logic        done_q;
    logic        accept;
    logic        last_bit;

    assign last_bit = (bit_q == (mode_q ? LAST_ID : LAST_BTN));

    // Next phase and the per-transition strobes.
    always_comb begin
        st_d     = st_q;
        accept   = 1'b0;
        sample_o = 1'b0;
        hit_o    = 1'b0;
        miss_o   = 1'b0;
        case (st_q)
            PH_IDLE: begin
                if (start_i) begin
                    st_d   = PH_PROBE_LO;
                    accept = 1'b1;
                end
            end
            PH_PROBE_LO: begin
                if (expire_i) begin
                    if (!sense_s_i) begin
                        st_d   = PH_IDLE;
                        miss_o = 1'b1;
                    end else begin
                        st_d = PH_PROBE_HI;
                    end
                end
            end
            PH_PROBE_HI: begin
                if (expire_i) begin
                    if (sense_s_i) begin
                        st_d   = PH_IDLE;
                        miss_o = 1'b1;
                    end else begin
                        st_d = PH_LOAD_HI;
                    end
                end
            end
            PH_LOAD_HI: if (expire_i) st_d = PH_LOAD_LO;
            PH_LOAD_LO: if (expire_i) st_d = PH_BIT_HI;
            PH_BIT_HI:  if (expire_i) st_d = PH_BIT_LO;
            PH_BIT_LO: begin
                if (expire_i) begin
                    sample_o = 1'b1;
                    if (last_bit) begin
                        st_d  = PH_IDLE;
                        hit_o = 1'b1;
                    end else begin
                        st_d = PH_BIT_HI;
                    end
                end
            end
            default: st_d = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= PH_IDLE;
        else        st_q <= st_d;
    end

    // Bit counter and transaction mode, both set at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q  <= '0;
            mode_q <= 1'b0;
        end else if (accept) begin
            bit_q  <= '0;
            mode_q <= id_mode_i;
        end else if (sample_o) begin
            bit_q  <= bit_q + 1'b1;
        end
    end

    // Done pulse, aligned with the result update and the return to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= hit_o | miss_o;
    end

    // Line levels for each phase.
    always_comb begin
        case (st_q)
            PH_PROBE_LO: lines_o = '{load: 1'b0, sclk: 1'b0, drv: 1'b0};
            PH_PROBE_HI: lines_o = '{load: 1'b0, sclk: 1'b1, drv: 1'b0};
            PH_LOAD_HI:  lines_o = '{load: 1'b1, sclk: 1'b1, drv: 1'b0};
            PH_LOAD_LO:  lines_o = '{load: 1'b0, sclk: 1'b1, drv: 1'b0};
            PH_BIT_HI:   lines_o = '{load: 1'b0, sclk: 1'b1, drv: 1'b0};
            PH_BIT_LO:   lines_o = '{load: 1'b0, sclk: 1'b0, drv: 1'b0};
            default:     lines_o = '{load: 1'b1, sclk: 1'b1, drv: 1'b1};
        endcase
    end

    assign latch_o   = accept;
    assign restart_o = accept | ((st_q != PH_IDLE) & expire_i);
    assign mode_o    = mode_q;
    assign busy_o    = (st_q != PH_IDLE);
    assign done_o    = done_q;

endmodule

// File: rtl/mtap_results.sv
// Per-socket shift registers and the result registers they commit into.
// Assumes: hit_i coincides with the final sample_i, so the committed value
// includes that last bit; miss_i never coincides with sample_i.
module mtap_results #(
    parameter int NPORT = 4,
    parameter int BITS  = 8,
    parameter int PW    = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NPORT-1:0]      data_s_i,
    input  logic                  sample_i,
    input  logic                  hit_i,
    input  logic                  miss_i,
    input  logic                  mode_i,
    output logic [NPORT*BITS-1:0] pads_o,
    output logic [NPORT-1:0]      id_o,
    output logic                  present_o,
    output logic [PW-1:0]         players_o
);

    for (genvar k = 0; k < NPORT; k++) begin : g_port
        logic [BITS-1:0] work_q;
        logic [BITS-1:0] work_d;
        logic [BITS-1:0] pad_q;
        logic            id_q;

        // First bit sampled ends up in the most significant position.
        assign work_d = {work_q[BITS-2:0], data_s_i[k]};

        // Collect this socket's serial stream.
        always_ff @(posedge clk) begin
            if (!rst_n)        work_q <= '0;
            else if (sample_i) work_q <= work_d;
        end

        // Commit the button byte, or clear it when no tap answered.
        always_ff @(posedge clk) begin
            if (!rst_n)                 pad_q <= '0;
            else if (hit_i && !mode_i)  pad_q <= work_d;
            else if (miss_i && !mode_i) pad_q <= '0;
        end

        // Commit the identity bit taken from the last sample.
        always_ff @(posedge clk) begin
            if (!rst_n)                id_q <= 1'b0;
            else if (hit_i && mode_i)  id_q <= work_d[0];
            else if (miss_i && mode_i) id_q <= 1'b0;
        end

        assign pads_o[k*BITS +: BITS] = pad_q;
        assign id_o[k]                = id_q;
    end

    // Presence flag and player count, updated on every completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            present_o <= 1'b0;
            players_o <= PW'(1);
        end else if (hit_i) begin
            present_o <= 1'b1;
            players_o <= PW'(NPORT);
        end else if (miss_i) begin
            present_o <= 1'b0;
            players_o <= PW'(1);
        end
    end

endmodule

// File: rtl/mtap_host.sv
// Host-side controller for one joystick port with a four-player tap.
// Probes for the tap, then reads either one button byte per socket or the
// tap identity. Assumes the tap returns sclk_o inverted on sense_i and
// shifts its sockets out together on rising sclk_o.
module mtap_host #(
    parameter int  NPORT       = 4,
    parameter int  BITS        = 8,
    parameter int  DWELL_W     = 8,
    parameter int  SYNC_STAGES = 2,
    localparam int PW          = $clog2(NPORT + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic                  id_mode_i,
    input  logic [DWELL_W-1:0]    dwell_i,
    input  logic [NPORT-1:0]      data_i,
    input  logic                  sense_i,
    output logic                  load_o,
    output logic                  sclk_o,
    output logic                  sense_drv_o,
    output logic                  busy_o,
    output logic                  done_o,
    output logic                  present_o,
    output logic [PW-1:0]         players_o,
    output logic [NPORT*BITS-1:0] pads_o,
    output logic [NPORT-1:0]      id_o
);
    import mtap_pkg::*;

    localparam int MIN_DWELL = SYNC_STAGES + 1;

    logic [NPORT:0]   in_s;
    logic             expire, latch, restart, sample, hit, miss, mode;
    lines_t           lines;

    mtap_sync #(.W(NPORT + 1), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({sense_i, data_i}),
        .q_o   (in_s)
    );

    mtap_dwell #(.DW(DWELL_W), .MIN(MIN_DWELL)) u_dwell (
        .clk       (clk),
        .rst_n     (rst_n),
        .latch_i   (latch),
        .dwell_i   (dwell_i),
        .restart_i (restart),
        .expire_o  (expire)
    );

    mtap_seq #(.BITS(BITS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .id_mode_i (id_mode_i),
        .sense_s_i (in_s[NPORT]),
        .expire_i  (expire),
        .latch_o   (latch),
        .restart_o (restart),
        .sample_o  (sample),
        .hit_o     (hit),
        .miss_o    (miss),
        .mode_o    (mode),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .lines_o   (lines)
    );

    mtap_results #(.NPORT(NPORT), .BITS(BITS), .PW(PW)) u_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_s_i  (in_s[NPORT-1:0]),
        .sample_i  (sample),
        .hit_i     (hit),
        .miss_i    (miss),
        .mode_i    (mode),
        .pads_o    (pads_o),
        .id_o      (id_o),
        .present_o (present_o),
        .players_o (players_o)
    );

    assign load_o      = lines.load;
    assign sclk_o      = lines.sclk;
    assign sense_drv_o = lines.drv;

endmodule

// File: rtl/mtap_host_chk.sv
// Protocol checker for mtap_host, attached through bind.
// Assumes: all inputs are the top-level ports of the bound instance.
module mtap_host_chk #(
    parameter int NPORT     = 4,
    parameter int PW        = 3,
    parameter int MIN_DWELL = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          busy_o,
    input logic          done_o,
    input logic          present_o,
    input logic [PW-1:0] players_o,
    input logic          load_o,
    input logic          sclk_o,
    input logic          sense_drv_o
);

    logic [2:0] lines, lines_q;
    logic       busy_q;
    logic [7:0] run_q;

    assign lines = {load_o, sclk_o, sense_drv_o};

    // Track how long the line levels have been stable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lines_q <= 3'b111;
            busy_q  <= 1'b0;
            run_q   <= '0;
        end else begin
            lines_q <= lines;
            busy_q  <= busy_o;
            if (lines != lines_q)  run_q <= '0;
            else if (run_q != 8'hFF) run_q <= run_q + 1'b1;
        end
    end

    assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (load_o && sclk_o && sense_drv_o));

    assert_players_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (players_o == (present_o ? PW'(NPORT) : PW'(1))));

    assert_load_clk_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |-> sclk_o);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && busy_q));

    assert_min_dwell_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((lines != lines_q) && busy_q) |-> (run_q >= 8'(MIN_DWELL - 1)));

    assert_start_only_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

endmodule

bind mtap_host mtap_host_chk #(.NPORT(NPORT), .PW(PW), .MIN_DWELL(MIN_DWELL)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .present_o   (present_o),
    .players_o   (players_o),
    .load_o      (load_o),
    .sclk_o      (sclk_o),
    .sense_drv_o (sense_drv_o)
);

// File: tb/tb_mtap_host.sv
// Scoreboard bench: a tap model answers the port lines, the driver queues
// expected results, and the monitor compares them on each done pulse.
module tb_mtap_host;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        id_mode_i = 1'b0;
    logic [7:0]  dwell_i = 8'd3;
    logic [3:0]  data_i;
    logic        sense_i;
    logic        load_o, sclk_o, sense_drv_o, busy_o, done_o, present_o;
    logic [2:0]  players_o;
    logic [31:0] pads_o;
    logic [3:0]  id_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit ended = 0;

    always #2 clk = ~clk;

    mtap_host dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .id_mode_i(id_mode_i),
        .dwell_i(dwell_i), .data_i(data_i), .sense_i(sense_i),
        .load_o(load_o), .sclk_o(sclk_o), .sense_drv_o(sense_drv_o),
        .busy_o(busy_o), .done_o(done_o), .present_o(present_o),
        .players_o(players_o), .pads_o(pads_o), .id_o(id_o)
    );

    // Tap model: four parallel-in shift registers plus an inverting sense.
    bit         attached = 0;
    bit         stuck_hi = 0;
    logic [7:0] btn [4];
    logic [3:0] si_lvl = 4'h0;
    logic [7:0] sr [4];

    initial begin
        for (int k = 0; k < 4; k++) begin
            btn[k] = 8'h00;
            sr[k]  = 8'h00;
        end
    end

    always @(posedge load_o or posedge sclk_o) begin
        for (int k = 0; k < 4; k++) begin
            if (load_o) sr[k] = btn[k];
            else        sr[k] = {sr[k][6:0], si_lvl[k]};
        end
    end

    assign data_i  = attached ? {sr[3][7], sr[2][7], sr[1][7], sr[0][7]} : 4'h0;
    assign sense_i = stuck_hi ? 1'b1 : (attached ? ~sclk_o : 1'b0);

    typedef struct {
        logic        present;
        logic [2:0]  players;
        logic [31:0] pads;
        logic [3:0]  id;
        int          eff;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [31:0] mdl_pads = 32'h0;
    logic [3:0]  mdl_id = 4'h0;

    task automatic chk(input bit ok, input string msg);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s", msg);
        end
    endtask

    task automatic finish_up();
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Driver: set the tap model, queue the expectation, pulse start.
    task automatic run_txn(input bit att, input bit stuck, input bit idm,
                           input logic [7:0] dw, input logic [31:0] bvec,
                           input logic [3:0] ids, input bit poke, input string tag);
        exp_t e;
        bit   pres;
        attached = att;
        stuck_hi = stuck;
        for (int k = 0; k < 4; k++) btn[k] = bvec[k*8 +: 8];
        si_lvl = ids;
        pres = att && !stuck;
        if (idm) mdl_id = pres ? ids : 4'h0;
        else     mdl_pads = pres ? bvec : 32'h0;
        e.present = pres;
        e.players = pres ? 3'd4 : 3'd1;
        e.pads    = mdl_pads;
        e.id      = mdl_id;
        e.eff     = (dw < 8'd3) ? 3 : int'(dw);
        e.tag     = tag;
        sb.push_back(e);
        @(negedge clk);
        start_i = 1'b1; id_mode_i = idm; dwell_i = dw;
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            repeat (30) @(negedge clk);
            start_i = 1'b1; id_mode_i = ~idm; dwell_i = 8'd3;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (sb.size() != 0) @(negedge clk);
        repeat (5) @(negedge clk);
    endtask

    // Monitor: measure hold lengths and compare results on each done.
    logic [2:0] prev_lines = 3'b111;
    bit         prev_busy = 0;
    int         run = 0;
    int         min_run = 1000;

    always @(negedge clk) begin
        if (rst_n) begin
            if ({load_o, sclk_o, sense_drv_o} != prev_lines) begin
                if (prev_busy && run < min_run) min_run = run;
                run = 1;
            end else begin
                run++;
            end
            prev_lines = {load_o, sclk_o, sense_drv_o};
            prev_busy  = busy_o;
            if (done_o) begin
                if (sb.size() == 0) begin
                    chk(0, "R11 unexpected extra done pulse: got 1 exp 0");
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(present_o == e.present, $sformatf("R2/R3 %s present got %0b exp %0b", e.tag, present_o, e.present));
                    chk(players_o == e.players, $sformatf("R4 %s players got %0d exp %0d", e.tag, players_o, e.players));
                    chk(pads_o == e.pads, $sformatf("R6/R7 %s pads got %h exp %h", e.tag, pads_o, e.pads));
                    chk(id_o == e.id, $sformatf("R8 %s id got %h exp %h", e.tag, id_o, e.id));
                    chk(min_run == e.eff, $sformatf("R10 %s hold got %0d exp %0d", e.tag, min_run, e.eff));
                    chk({load_o, sclk_o, sense_drv_o, busy_o} == 4'b1110,
                        $sformatf("R9 %s end lines/busy got %b exp 1110", e.tag, {load_o, sclk_o, sense_drv_o, busy_o}));
                end
                min_run = 1000;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog expired: got running exp finished");
        finish_up();
    end

    // Stimulus.
    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset and idle state
        chk({load_o, sclk_o, sense_drv_o} == 3'b111, $sformatf("R1 idle lines got %b exp 111", {load_o, sclk_o, sense_drv_o}));
        chk(!busy_o && !done_o, $sformatf("R1 busy/done got %b%b exp 00", busy_o, done_o));
        chk(!present_o && players_o == 3'd1, $sformatf("R1 present/players got %0b/%0d exp 0/1", present_o, players_o));
        chk(pads_o == 32'h0 && id_o == 4'h0, $sformatf("R1 pads/id got %h/%h exp 0/0", pads_o, id_o));

        // R2: no tap, sense reads low in the first probe
        run_txn(0, 0, 0, 8'd3, 32'h1234_5678, 4'h0, 0, "absent");
        // R5 R6 R7: button read, distinct byte per socket
        run_txn(1, 0, 0, 8'd3, 32'h01F0_3CA5, 4'h0, 0, "read_a");
        // R10: dwell below minimum is clamped
        run_txn(1, 0, 0, 8'd0, 32'h7E81_FF00, 4'h5, 0, "read_b");
        // R8: identity read, pads must stay
        run_txn(1, 0, 1, 8'd5, 32'hFFFF_FFFF, 4'hA, 0, "id_a");
        // R3: sense stuck high fails the second probe
        run_txn(1, 1, 0, 8'd4, 32'hAAAA_AAAA, 4'h0, 0, "stuck");
        // R11: second start during a long read is ignored
        run_txn(1, 0, 0, 8'd10, 32'h8040_2010, 4'h3, 1, "poke");
        // R9: absent identity read clears id only
        run_txn(1, 0, 1, 8'd3, 32'h0000_0000, 4'h6, 0, "id_b");
        run_txn(0, 0, 1, 8'd3, 32'h0000_0000, 4'h0, 0, "id_absent");

        repeat (50) @(negedge clk);
        chk(sb.size() == 0, $sformatf("R11 pending expectations got %0d exp 0", sb.size()));
        chk(!busy_o, $sformatf("R1 final busy got %0b exp 0", busy_o));
        finish_up();
    end

endmodule